// File: doc/BRIEF.md
# Clock Output Router and Gate

This block sits between the output dividers of a clock generator and its output pads. For every output channel it picks one of two sources: the channel's own divided PLL clock, or a direct copy of the reference input clock (bypass). The chosen clock can be inverted. The result is then gated so that nothing unstable reaches the pad. A channel that uses the PLL stays low until the PLL reports lock. An active-low power-down input forces every output low at once, without waiting for any clock edge.

A change of source on a running channel goes through a break-before-make handover. The old clock's enable is dropped during that clock's low phase. The new clock's enable is raised only after the drop has been seen, through a synchroniser in the new clock's domain. The release from power-down and the lock flag also pass through synchronisers in each output domain, so gating always begins and ends on a low phase. Channels 0 and 1 can be joined into one differential pair: channel 1 then carries the exact complement of channel 0. Before lock the pair rests with the true side low and the complement side high.

The block also passes through a 2-bit drive-strength code for each single-ended output. Bypassed outputs carry the reference clock itself, so they never show the spread-spectrum modulation that the PLL path may carry.

Top module: `clk_out_router`

## Requirements
- R1: With `cfg_bypass[i]`=1, output i follows `ref_clk`. With `cfg_bypass[i]`=0 it follows `pll_clk[i]`. Each channel selects its source independently of the others.
- R2: With `cfg_invert[i]`=1, output i carries the complement of its selected source clock. This applies in bypass as well as on the PLL path.
- R3: A channel with `cfg_bypass[i]`=0 holds its output low while `pll_locked` is 0. A bypassed channel runs whatever the state of `pll_locked`.
- R4: While `pwrdn_n` is 0, all outputs are 0. They fall without waiting for a clock edge. After `pwrdn_n` returns to 1, each output resumes its configured behaviour once its synchronisers have passed the release.
- R5: When `cfg_bypass[i]` changes on a running channel, the output shows no high or low pulse shorter than the shorter half-period of the two sources. The two source enables of a channel are never active together.
- R6: With `cfg_diff`=1 and `pwrdn_n`=1, output 1 is the complement of output 0 at all times. Before lock this gives output 0 low and output 1 high.
- R7: With `cfg_diff`=1, `cfg_bypass[1]` and `cfg_invert[1]` have no effect on output 1.
- R8: Bits [2i+1:2i] of `drv_code` equal bits [2i+1:2i] of `cfg_drive` for every single-ended channel i. With `cfg_diff`=1, the fields of channels 0 and 1 read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | NUM_CH | Divided PLL clock, one per channel |
| ref_clk | input | 1 | Reference input clock used in bypass |
| pll_locked | input | 1 | PLL lock flag, asynchronous to all clocks |
| pwrdn_n | input | 1 | Active-low power-down, asynchronous |
| cfg_bypass | input | NUM_CH | Per-channel source select, 1 = reference clock |
| cfg_invert | input | NUM_CH | Per-channel output inversion |
| cfg_diff | input | 1 | Join channels 0 and 1 into a true/complement pair |
| cfg_drive | input | NUM_CH*DRV_W | Drive-strength code per channel, 2 bits each |
| clk_out | output | NUM_CH | Gated output clocks |
| drv_code | output | NUM_CH*DRV_W | Drive-strength code presented to the output buffers |

## Verification
The bench builds the block with its defaults: three channels, 2-bit drive codes and two-stage synchronisers. The short synchronisers keep every handover and release within a few hundred nanoseconds. This lets the bench switch sources at several different phases and still finish quickly. The three PLL clocks run at periods unrelated to each other and to the 200 MHz reference. Each crossing is therefore truly asynchronous, and the pulse-width monitor on channel 0 sees the handover from both directions. The three channels also cover every mix of bypass, inversion and differential pairing.

// File: rtl/clkrt_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the per-channel configuration type of the
// output router. Assumes configuration is quasi-static (changed while powered
// down, except for the source select, which may change at any time).
package clkrt_pkg;
    localparam int unsigned DEF_CH    = 3;
    localparam int unsigned DEF_DRV_W = 2;
    localparam int unsigned DEF_SYNC  = 2;

    // Per-channel selection: source and polarity.
    typedef struct packed {
        logic bypass;
        logic invert;
    } chan_cfg_t;
endpackage

// File: rtl/clkrt_sync.sv
`timescale 1ns/1ps
// Module: clkrt_sync
// Multi-flop synchroniser for a level into the domain of clk. Assumes STAGES >= 2
// and that d is a level that stays put for several clk periods. There is no
// separate reset: callers fold the active-low power-down into d, so the chain
// clears itself within STAGES edges.
module clkrt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the chain.
    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkrt_lowgate.sv
`timescale 1ns/1ps
// Module: clkrt_lowgate
// Captures enable bits at the edge that begins the low phase of the gated
// clock (clk ^ inv). This is the falling edge of clk when inv is 0 and the
// rising edge when inv is 1, so an AND gate using q never clips a high phase.
// Assumes inv is static while the channel runs.
module clkrt_lowgate #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         inv,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] fall_q;
    logic [W-1:0] rise_q;

    // Capture on the falling edge, used for the non-inverted polarity.
    always_ff @(negedge clk) begin
        fall_q <= d;
    end

    // Capture on the rising edge, used for the inverted polarity.
    always_ff @(posedge clk) begin
        rise_q <= d;
    end

    assign q = inv ? rise_q : fall_q;
endmodule

// File: rtl/clkrt_chan.sv
`timescale 1ns/1ps
// Module: clkrt_chan
// One output channel. It chooses between pll_clk and ref_clk with a
// break-before-make handover and applies inversion. The PLL path is gated by
// lock. Each request is synchronised into the clock domain it enables, and
// each enable changes only in that clock's low phase. The result clk_pre has
// not yet been gated by power-down; the top applies that asynchronously.
module clkrt_chan #(
    parameter int unsigned SYNC_STAGES = clkrt_pkg::DEF_SYNC
) (
    input  logic                 pll_clk,
    input  logic                 ref_clk,
    input  logic                 pwrdn_n,
    input  logic                 pll_locked,
    input  clkrt_pkg::chan_cfg_t cfg,
    output logic                 clk_pre
);
    logic pll_req, pll_req_s, lock_s, pll_own, pll_pass;
    logic ref_req, ref_req_s, ref_own;

    // The PLL side may claim the output only once the reference side has let go.
    assign pll_req = pwrdn_n & ~cfg.bypass & ~ref_own;

    clkrt_sync #(.STAGES(SYNC_STAGES)) u_pll_req_sync (
        .clk (pll_clk),
        .d   (pll_req),
        .q   (pll_req_s)
    );

    clkrt_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
        .clk (pll_clk),
        .d   (pll_locked & pwrdn_n),
        .q   (lock_s)
    );

    clkrt_lowgate #(.W(2)) u_pll_gate (
        .clk (pll_clk),
        .inv (cfg.invert),
        .d   ({pll_req_s & lock_s, pll_req_s}),
        .q   ({pll_pass, pll_own})
    );

    // The reference side may claim the output only once the PLL side has let go.
    assign ref_req = pwrdn_n & cfg.bypass & ~pll_own;

    clkrt_sync #(.STAGES(SYNC_STAGES)) u_ref_req_sync (
        .clk (ref_clk),
        .d   (ref_req),
        .q   (ref_req_s)
    );

    clkrt_lowgate #(.W(1)) u_ref_gate (
        .clk (ref_clk),
        .inv (cfg.invert),
        .d   (ref_req_s),
        .q   (ref_own)
    );

    // Combine the two gated, polarity-adjusted sources.
    assign clk_pre = ((pll_clk ^ cfg.invert) & pll_pass)
                   | ((ref_clk ^ cfg.invert) & ref_own);

    // The two enables of a channel are exclusive.
    AST_ONE_OWNER: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        !(pll_own && ref_own)); // R5

    // An unlocked PLL path never opens its gate (non-inverted capture timing).
    AST_UNLOCKED_OFF: assert property (@(posedge pll_clk) disable iff (!pwrdn_n)
        (!lock_s && !cfg.invert) |-> !pll_pass); // R3
endmodule

// File: rtl/clk_out_router.sv
`timescale 1ns/1ps
// Module: clk_out_router
// Top of the output routing block. Builds NUM_CH channels, joins channels 0
// and 1 into a true/complement pair on request, applies the asynchronous
// power-down to every output and presents the per-channel drive codes.
// Assumes NUM_CH >= 2 and that cfg_invert and cfg_diff change only while
// pwrdn_n is low.
module clk_out_router #(
    parameter int unsigned NUM_CH      = clkrt_pkg::DEF_CH,
    parameter int unsigned DRV_W       = clkrt_pkg::DEF_DRV_W,
    parameter int unsigned SYNC_STAGES = clkrt_pkg::DEF_SYNC
) (
    input  logic [NUM_CH-1:0]       pll_clk,
    input  logic                    ref_clk,
    input  logic                    pll_locked,
    input  logic                    pwrdn_n,
    input  logic [NUM_CH-1:0]       cfg_bypass,
    input  logic [NUM_CH-1:0]       cfg_invert,
    input  logic                    cfg_diff,
    input  logic [NUM_CH*DRV_W-1:0] cfg_drive,
    output logic [NUM_CH-1:0]       clk_out,
    output logic [NUM_CH*DRV_W-1:0] drv_code
);
    localparam int unsigned PAIR_CH = 2;

    logic [NUM_CH-1:0] pre_clk;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkrt_pkg::chan_cfg_t ch_cfg;

        // Collect the channel's own selection bits.
        assign ch_cfg = '{bypass: cfg_bypass[i], invert: cfg_invert[i]};

        clkrt_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .pll_clk    (pll_clk[i]),
            .ref_clk    (ref_clk),
            .pwrdn_n    (pwrdn_n),
            .pll_locked (pll_locked),
            .cfg        (ch_cfg),
            .clk_pre    (pre_clk[i])
        );

        if (i == 1) begin : g_pair_neg
            // Complement side follows channel 0 when paired.
            assign clk_out[i] = pwrdn_n & (cfg_diff ? ~pre_clk[0] : pre_clk[i]);
        end else begin : g_plain
            // Single-ended (or true side): power-down gate only.
            assign clk_out[i] = pwrdn_n & pre_clk[i];
        end

        if (i < PAIR_CH) begin : g_drv_pair
            // Paired channels carry no single-ended drive setting.
            assign drv_code[i*DRV_W +: DRV_W] = cfg_diff ? '0 : cfg_drive[i*DRV_W +: DRV_W];
        end else begin : g_drv_se
            assign drv_code[i*DRV_W +: DRV_W] = cfg_drive[i*DRV_W +: DRV_W];
        end
    end

    // The paired outputs are always opposite while powered.
    AST_DIFF_COMPL: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        cfg_diff |-> (clk_out[1] == !clk_out[0])); // R6

    // Paired channels present a zero drive code.
    AST_DIFF_DRV: assert property (@(posedge ref_clk) disable iff (!pwrdn_n)
        cfg_diff |-> (drv_code[PAIR_CH*DRV_W-1:0] == '0)); // R8
endmodule

// File: tb/sim_clk_out_router.sv
`timescale 1ns/1ps
// Directed bench for clk_out_router: one task per scenario, each checking its
// own results by sampling the outputs between clock edges.
module sim_clk_out_router;
    localparam int K_LOW = 0;
    localparam int K_REF = 1;
    localparam int K_P0  = 2;
    localparam int K_P1  = 3;
    localparam int K_P2  = 4;

    logic       ref_clk = 1'b0;
    logic       pclk0 = 1'b0, pclk1 = 1'b0, pclk2 = 1'b0;
    logic       pll_locked = 1'b0;
    logic       pwrdn_n = 1'b0;
    logic [2:0] cfg_bypass = '0;
    logic [2:0] cfg_invert = '0;
    logic       cfg_diff = 1'b0;
    logic [5:0] cfg_drive = 6'b11_10_01;
    logic [2:0] clk_out;
    logic [5:0] drv_code;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 ref_clk = ~ref_clk;
    always #4   pclk0 = ~pclk0;
    always #6   pclk1 = ~pclk1;
    always #7   pclk2 = ~pclk2;

    clk_out_router u0 (
        .pll_clk    ({pclk2, pclk1, pclk0}),
        .ref_clk    (ref_clk),
        .pll_locked (pll_locked),
        .pwrdn_n    (pwrdn_n),
        .cfg_bypass (cfg_bypass),
        .cfg_invert (cfg_invert),
        .cfg_diff   (cfg_diff),
        .cfg_drive  (cfg_drive),
        .clk_out    (clk_out),
        .drv_code   (drv_code)
    );

    // Pulse-width monitor on output 0.
    logic    o0;
    realtime t_last = 0.0;
    int      glitch_cnt = 0;
    bit      mon_en = 1'b0;
    assign o0 = clk_out[0];
    always @(o0) begin
        if (mon_en && ($realtime - t_last) < 2.4) glitch_cnt++;
        t_last = $realtime;
    end

    task automatic settle();
        #300;
    endtask

    // Compare output ch with the expected waveform at 48 mid-phase points.
    task automatic check_win(input int ch, input int kind, input logic inv, input string tag);
        int   bad = 0;
        logic act = 1'b0, expv = 1'b0, a0 = 1'b0, e0 = 1'b0;
        @(posedge ref_clk);
        #0.3;
        for (int k = 0; k < 48; k++) begin
            case (kind)
                K_REF:   expv = ref_clk;
                K_P0:    expv = pclk0;
                K_P1:    expv = pclk1;
                K_P2:    expv = pclk2;
                default: expv = 1'b0;
            endcase
            expv = expv ^ inv;
            act  = clk_out[ch];
            if (act !== expv) begin
                if (bad == 0) begin a0 = act; e0 = expv; end
                bad++;
            end
            #1;
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s ch%0d: got %b expected %b (%0d of 48 samples differ)", tag, ch, a0, e0, bad);
        end
    endtask

    task automatic check_drv(input logic [5:0] expv, input string tag);
        n_chk++;
        if (drv_code !== expv) begin
            n_fail++;
            $display("FAIL %s drv_code: got %b expected %b", tag, drv_code, expv);
        end
    endtask

    task automatic t_reset();
        #20;
        for (int c = 0; c < 3; c++) check_win(c, K_LOW, 1'b0, "R4 held in power-down");
        check_drv(6'b11_10_01, "R8 drive codes pass through");
    endtask

    task automatic t_prelock();
        cfg_bypass = 3'b100;
        pwrdn_n = 1'b1;
        settle();
        check_win(0, K_LOW, 1'b0, "R3 unlocked pll channel low");
        check_win(1, K_LOW, 1'b0, "R3 unlocked pll channel low");
        check_win(2, K_REF, 1'b0, "R1 R3 bypass runs before lock");
    endtask

    task automatic t_locked();
        pll_locked = 1'b1;
        settle();
        check_win(0, K_P0, 1'b0, "R1 pll source ch0");
        check_win(1, K_P1, 1'b0, "R1 pll source ch1");
        check_win(2, K_REF, 1'b0, "R1 bypass ch2");
    endtask

    task automatic t_invert();
        pwrdn_n = 1'b0;
        cfg_invert = 3'b110;
        #20;
        pwrdn_n = 1'b1;
        settle();
        check_win(0, K_P0, 1'b0, "R2 non-inverted neighbour");
        check_win(1, K_P1, 1'b1, "R2 inverted pll path");
        check_win(2, K_REF, 1'b1, "R2 inverted bypass");
    endtask

    task automatic t_pwrdn();
        logic [2:0] snap;
        @(posedge pclk1);
        #1.1;
        pwrdn_n = 1'b0;
        #0.1;
        snap = clk_out;
        n_chk++;
        if (snap !== 3'b000) begin
            n_fail++;
            $display("FAIL R4 immediate power-down: got %b expected 000", snap);
        end
        check_win(1, K_LOW, 1'b0, "R4 stays low");
        pwrdn_n = 1'b1;
        settle();
        check_win(1, K_P1, 1'b1, "R4 resumes after release");
    endtask

    task automatic t_handover();
        mon_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #(3.7 * (k + 1));
            cfg_bypass[0] = 1'b1;
            settle();
            check_win(0, K_REF, 1'b0, "R1 R5 switched to reference");
            #(2.9 * (k + 1));
            cfg_bypass[0] = 1'b0;
            settle();
            check_win(0, K_P0, 1'b0, "R1 R5 switched back to pll");
        end
        mon_en = 1'b0;
        n_chk++;
        if (glitch_cnt != 0) begin
            n_fail++;
            $display("FAIL R5 short pulses during handover: got %0d expected 0", glitch_cnt);
        end
    endtask

    task automatic t_diff();
        pwrdn_n = 1'b0;
        pll_locked = 1'b0;
        cfg_diff = 1'b1;
        cfg_bypass = 3'b010;
        cfg_invert = 3'b010;
        #20;
        pwrdn_n = 1'b1;
        settle();
        check_win(0, K_LOW, 1'b0, "R6 pair true side low before lock");
        check_win(1, K_LOW, 1'b1, "R6 R7 pair complement high before lock");
        check_drv(6'b11_00_00, "R8 paired channels drive 00");
        pll_locked = 1'b1;
        settle();
        check_win(0, K_P0, 1'b0, "R6 pair true side");
        check_win(1, K_P0, 1'b1, "R6 R7 pair complement ignores ch1 bits");
    endtask

    initial begin
        t_reset();
        t_prelock();
        t_locked();
        t_invert();
        t_pwrdn();
        t_handover();
        t_diff();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule